// File: doc/BRIEF.md
# Compressed Line Offset Calculator

This block turns the position of a cache line inside an uncompressed 8 KB page into the byte offset where that line starts inside the compressed copy of the page. The page is split into eight 1 KB subpages of sixteen 64-byte lines each. Every subpage and every line carries a 2-bit size class. The block converts each class to an allocated byte count, hysteresis slack included. It then adds the allocations of all subpages ahead of the target subpage to the allocations of the lines ahead of the target line within its own subpage.

The block also reports whether the target line is in the all-zero class. For such a line the caller can return zeros without issuing a memory read. Requests enter and results leave through valid/ready handshakes across a two-stage pipeline. A transfer happens on a clock edge where both valid and ready are high. A result waiting at the output holds steady until the consumer takes it. While the output is stalled and the first stage is occupied, the block lowers `in_ready`.

Top module: `clo_offset_calc`

## Requirements
- R1: For a target index `t`, the subpage is `t[6:4]` and the line within it is `t[3:0]`. `out_offset` equals the sum of the allocations of subpages 0 to `t[6:4]-1` plus the sum of the allocations of lines 0 to `t[3:0]-1` of subpage `t[6:4]`.
- R2: Subpage `j` takes its class from `in_sub_codes[2j+1:2j]`. Class 0 allocates 0 bytes. Classes 1, 2 and 3 allocate 256, 512 and 1024 bytes plus a 32-byte slack, giving 288, 544 and 1056 bytes.
- R3: Line `k` of subpage `j` takes its class from `in_line_codes[2(16j+k)+1 : 2(16j+k)]`. Class 0 allocates 0 bytes and receives no slack. Classes 1, 2 and 3 allocate 16, 32 and 64 bytes plus an 8-byte slack, giving 24, 40 and 72 bytes. The offset therefore never exceeds 8472.
- R4: `out_zero` is 1 exactly when the class code of the target line is 0.
- R5: A request is accepted on an edge where `in_valid` and `in_ready` are both high. If `out_ready` stays high, its result shows `out_valid` high after the second following edge. `in_ready` is low only when both pipeline stages hold data and the output is stalled.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_offset` and `out_zero` hold their values. Results leave in the order their requests were accepted, each exactly once.
- R7: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_sub_codes | input | 16 | Size class of each of the 8 subpages |
| in_line_codes | input | 256 | Size class of each of the 128 lines |
| in_line_idx | input | 7 | Target line index within the page |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_offset | output | 14 | Byte offset of the target line in the compressed page |
| out_zero | output | 1 | Target line is all zeros, no memory read needed |

## Verification
Two things can happen in the same cycle: a new request is accepted, and a stalled result is held or released. The bench fills both stages while `out_ready` is low. It checks that `in_ready` drops, and that the first result stays frozen through the stall. It then raises `out_ready` and checks that both results leave in order with the offsets and zero flags the reference sum predicts. The offset values themselves are judged against a sum over the size classes, computed in the bench for table-driven pages and for hand-worked corner pages.

// File: rtl/clo_pkg.sv
package clo_pkg;
  localparam int CODE_W     = 2;
  localparam int LINE_SLACK = 8;
  localparam int SUB_SLACK  = 32;
  localparam int ALLOC_W    = 11;

  // Allocated bytes for a line class; the zero class gets no slack.
  function automatic logic [ALLOC_W-1:0] line_alloc(input logic [CODE_W-1:0] c);
    case (c)
      2'd0:    line_alloc = ALLOC_W'(0);
      2'd1:    line_alloc = ALLOC_W'(16 + LINE_SLACK);
      2'd2:    line_alloc = ALLOC_W'(32 + LINE_SLACK);
      default: line_alloc = ALLOC_W'(64 + LINE_SLACK);
    endcase
  endfunction

  // Allocated bytes for a subpage class.
  function automatic logic [ALLOC_W-1:0] sub_alloc(input logic [CODE_W-1:0] c);
    case (c)
      2'd0:    sub_alloc = ALLOC_W'(0);
      2'd1:    sub_alloc = ALLOC_W'(256 + SUB_SLACK);
      2'd2:    sub_alloc = ALLOC_W'(512 + SUB_SLACK);
      default: sub_alloc = ALLOC_W'(1024 + SUB_SLACK);
    endcase
  endfunction
endpackage

// File: rtl/clo_sub_sum.sv
module clo_sub_sum
  import clo_pkg::*;
#(
  parameter int SUBPAGES = 8,
  parameter int SUM_W    = 14,
  localparam int SIDX_W  = $clog2(SUBPAGES)
) (
  input  logic [SUBPAGES*CODE_W-1:0] codes,
  input  logic [SIDX_W-1:0]          tgt,
  output logic [SUM_W-1:0]           sum
);
  logic [SUM_W-1:0] part [SUBPAGES];

  for (genvar j = 0; j < SUBPAGES; j++) begin : g_conv
    assign part[j] = (SIDX_W'(j) < tgt)
                   ? SUM_W'(sub_alloc(codes[j*CODE_W +: CODE_W]))
                   : '0;
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < SUBPAGES; j++) sum = sum + part[j];
  end
endmodule

// File: rtl/clo_line_sum.sv
module clo_line_sum
  import clo_pkg::*;
#(
  parameter int LINES   = 16,
  parameter int SUM_W   = 14,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic [LINES*CODE_W-1:0] codes,
  input  logic [LIDX_W-1:0]       tgt,
  output logic [SUM_W-1:0]        sum,
  output logic                    zero
);
  logic [SUM_W-1:0] part [LINES];

  for (genvar k = 0; k < LINES; k++) begin : g_conv
    assign part[k] = (LIDX_W'(k) < tgt)
                   ? SUM_W'(line_alloc(codes[k*CODE_W +: CODE_W]))
                   : '0;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < LINES; k++) sum = sum + part[k];
  end

  assign zero = (codes[tgt*CODE_W +: CODE_W] == '0);
endmodule

// File: rtl/clo_offset_calc.sv
module clo_offset_calc
  import clo_pkg::*;
#(
  parameter int SUBPAGES = 8,
  parameter int LINES    = 16,
  parameter int OFF_W    = 14,
  localparam int SIDX_W  = $clog2(SUBPAGES),
  localparam int LIDX_W  = $clog2(LINES),
  localparam int IDX_W   = SIDX_W + LIDX_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [SUBPAGES*CODE_W-1:0]        in_sub_codes,
  input  logic [SUBPAGES*LINES*CODE_W-1:0]  in_line_codes,
  input  logic [IDX_W-1:0]                  in_line_idx,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [OFF_W-1:0]                  out_offset,
  output logic                              out_zero
);
  logic [SIDX_W-1:0]         tgt_sub;
  logic [LIDX_W-1:0]         tgt_line;
  logic [LINES*CODE_W-1:0]   sub_lines;
  logic [OFF_W-1:0]          sub_sum, line_sum;
  logic                      line_zero;

  assign tgt_sub   = in_line_idx[IDX_W-1 -: SIDX_W];
  assign tgt_line  = in_line_idx[LIDX_W-1:0];
  assign sub_lines = in_line_codes[tgt_sub*(LINES*CODE_W) +: LINES*CODE_W];

  clo_sub_sum #(.SUBPAGES(SUBPAGES), .SUM_W(OFF_W)) u_sub (
    .codes(in_sub_codes), .tgt(tgt_sub), .sum(sub_sum)
  );

  clo_line_sum #(.LINES(LINES), .SUM_W(OFF_W)) u_line (
    .codes(sub_lines), .tgt(tgt_line), .sum(line_sum), .zero(line_zero)
  );

  // stage 1: partial sums
  logic             s1_valid;
  logic [OFF_W-1:0] s1_sub, s1_line;
  logic             s1_zero;
  logic             s2_take, s1_take;

  assign s2_take  = !out_valid || out_ready;
  assign s1_take  = !s1_valid || s2_take;
  assign in_ready = s1_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sub   <= '0;
      s1_line  <= '0;
      s1_zero  <= 1'b0;
    end else if (s1_take) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sub  <= sub_sum;
        s1_line <= line_sum;
        s1_zero <= line_zero;
      end
    end
  end

  // stage 2: final add, registered output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_zero   <= 1'b0;
    end else if (s2_take) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_offset <= s1_sub + s1_line;
        out_zero   <= s1_zero;
      end
    end
  end
endmodule

// File: rtl/clo_offset_calc_chk.sv
module clo_offset_calc_chk
  import clo_pkg::*;
#(
  parameter int SUBPAGES = 8,
  parameter int LINES    = 16,
  parameter int OFF_W    = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OFF_W-1:0] out_offset,
  input logic             out_zero,
  input logic             s1_valid
);
  localparam int MAX_OFF = (SUBPAGES-1)*(1024+SUB_SLACK) + (LINES-1)*(64+LINE_SLACK);

  // R6: stalled result holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_zero));

  // R3: offset bounded
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_offset) <= MAX_OFF);

  // R5: accepted request lands in stage 1
  p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  // R5: stage 1 advances to the output when it is free
  p_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && (!out_valid || out_ready) |=> out_valid);

  // R7: nothing valid straight after reset
  p_reset_r7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind clo_offset_calc clo_offset_calc_chk #(
  .SUBPAGES(SUBPAGES), .LINES(LINES), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
  .out_zero(out_zero), .s1_valid(s1_valid)
);

// File: tb/clo_offset_calc_tb.sv
module clo_offset_calc_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [15:0]  in_sub_codes = '0;
  logic [255:0] in_line_codes = '0;
  logic [6:0]   in_line_idx = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [13:0]  out_offset;
  logic         out_zero;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  clo_offset_calc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub_codes(in_sub_codes), .in_line_codes(in_line_codes),
    .in_line_idx(in_line_idx), .out_valid(out_valid), .out_ready(out_ready),
    .out_offset(out_offset), .out_zero(out_zero)
  );

  typedef struct packed {
    logic [15:0] sub;
    logic [31:0] lines;
    logic [6:0]  idx;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'hFFFF, 32'hFFFF_FFFF, 7'h7F},
    '{16'h0000, 32'h0000_0000, 7'h7F},
    '{16'h5555, 32'hAAAA_AAAA, 7'h25},
    '{16'hE4E4, 32'h1B1B_1B1B, 7'h3A},
    '{16'h1234, 32'h0F0F_F0F0, 7'h4C},
    '{16'hC0DE, 32'h9876_5432, 7'h13},
    '{16'hFFFF, 32'h0000_0001, 7'h01},
    '{16'hA5A5, 32'hFFFF_FFF0, 7'h62}
  };

  // reference model built from R1-style sums of R2/R3 allocations
  function automatic int sub_bytes(input logic [1:0] c);
    int t [4] = '{0, 288, 544, 1056};
    return t[c];
  endfunction
  function automatic int line_bytes(input logic [1:0] c);
    int t [4] = '{0, 24, 40, 72};
    return t[c];
  endfunction
  function automatic int ref_off(input logic [15:0] s, input logic [255:0] l,
                                 input logic [6:0] idx);
    int acc = 0;
    for (int j = 0; j < int'(idx[6:4]); j++) acc += sub_bytes(s[2*j +: 2]);
    for (int k = 0; k < int'(idx[3:0]); k++)
      acc += line_bytes(l[2*(16*int'(idx[6:4]) + k) +: 2]);
    return acc;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request, out_ready high; result visible two edges later
  task automatic run_one(input logic [15:0] s, input logic [255:0] l,
                         input logic [6:0] idx, input int exp_off,
                         input bit exp_zero, input string tag);
    @(negedge clk);
    in_sub_codes = s; in_line_codes = l; in_line_idx = idx; in_valid = 1'b1;
    check({tag, " R5 in_ready"}, int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R5 not early"}, int'(out_valid), 0);
    @(negedge clk);
    check({tag, " R5 out_valid"}, int'(out_valid), 1);
    check({tag, " R1 offset"}, int'(out_offset), exp_off);
    check({tag, " R4 zero"}, int'(out_zero), int'(exp_zero));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [255:0] pg;
    int           exp_a, exp_b;
    // R7 reset state
    repeat (3) @(negedge clk);
    check("R7 out_valid in reset", int'(out_valid), 0);
    check("R7 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;

    // table walk (R1 R2 R3 R4)
    foreach (VEC[i]) begin
      pg = {8{VEC[i].lines}};
      run_one(VEC[i].sub, pg, VEC[i].idx, ref_off(VEC[i].sub, pg, VEC[i].idx),
              pg[2*int'(VEC[i].idx) +: 2] == 2'b00, $sformatf("vec%0d", i));
    end

    // directed, hand-worked values
    run_one('1, '1, 7'h7F, 8472, 1'b0, "R3 max offset");
    run_one('0, '0, 7'h7F, 0, 1'b1, "R3 all zero class");
    run_one(16'h5555, {128{2'b10}}, 7'h25, 776, 1'b0, "R2 mixed");
    run_one('1, '1, 7'h00, 0, 1'b0, "R1 first line");
    // zero-class line after nonzero lines gets no slack: lines 0..2 class 1, line 3 zero
    pg = '1; pg[7:0] = 8'b00_01_01_01;
    run_one(16'h0000, pg, 7'h04, 72, 1'b0, "R3 zero line no slack");
    run_one(16'h0000, pg, 7'h03, 72, 1'b1, "R4 zero target");

    // R5/R6 back-pressure: accept and stall in the same cycles
    pg = {128{2'b11}};
    exp_a = ref_off(16'hFFFF, pg, 7'h11);
    exp_b = ref_off(16'hFFFF, pg, 7'h22);
    @(negedge clk);
    out_ready = 1'b0;
    in_sub_codes = 16'hFFFF; in_line_codes = pg; in_line_idx = 7'h11; in_valid = 1'b1;
    @(negedge clk);
    in_line_idx = 7'h22;
    check("R5 ready with stage1 free", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 ready low when full", int'(in_ready), 0);
    check("R6 first held offset", int'(out_offset), exp_a);
    repeat (3) @(negedge clk);
    check("R6 held valid", int'(out_valid), 1);
    check("R6 held offset", int'(out_offset), exp_a);
    out_ready = 1'b1;
    @(negedge clk);
    check("R6 second in order", int'(out_offset), exp_b);
    check("R6 second valid", int'(out_valid), 1);
    @(negedge clk);
    check("R6 no duplicate", int'(out_valid), 0);

    // R7 reset clears a pending result
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 reset drops output", int'(out_valid), 0);
    check("R7 reset ready", int'(in_ready), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule